// File: doc/BRIEF.md
# Configurable Serial Audio Input Receiver

This block takes stereo PCM samples from an external converter over a three-wire serial link (bit clock, word clock, data) and turns them into parallel left/right sample pairs. All three serial lines pass through two-flop synchronizers into the system clock domain. Clock edges are found there, so the system clock must run at least four times faster than the bit clock.

A format register sets five things at run time: the framing mode, the bit order, which bit clock edge samples data, which word clock level marks the left channel, and where left/right pairing starts. A second register picks what feeds the downstream encoder: the serial receiver or an alternate parallel stream. Writing a format value that differs from the current one restarts the framing logic.

The framing state machine has three states. FR_SEEK is entered after any reset or restart. It leaves for FR_HUNT on the first sampling edge, which records the word clock level. FR_HUNT moves to FR_WORD on the first sampling edge that sees a word clock change. FR_WORD stays in FR_WORD and ends one word at every later word clock change. A restart forces FR_SEEK from any state.

Top module: `serial_audio_rx`

## Requirements
- R1: After hardware reset, or after a one-cycle `sw_rst` pulse, both registers read 0x00 and `overflow` is 0. The format register (`reg_sel`=0) keeps bits 4:0; its bits 7:5 always read 0. The source register (`reg_sel`=1) keeps bit 0; its bits 7:1 always read 0.
- R2: With source bit 0 clear, each `alt_valid` cycle shows up one cycle later as `out_valid` carrying `alt_left`/`alt_right`, and serial pairs are discarded. With the bit set, only serial pairs are output.
- R3: Format bit 0 clear (aligned mode): the first bit of a word is sampled on the same bit clock sampling edge where the word clock changes. Bit 0 set (I2S mode): that sample is the last bit of the previous word, and the new word starts one bit clock later.
- R4: Format bit 1 clear: words arrive LSB first. Bit 1 set: words arrive MSB first.
- R5: Format bit 2 clear: data is sampled on the rising edge of the bit clock. Bit 2 set: data is sampled on the falling edge.
- R6: Format bit 3 clear: a word sent while the word clock is low is the left sample. Bit 3 set: a word sent while the word clock is high is the left sample.
- R7: Format bit 4 clear: the first two words after a restart form the first couple. Bit 4 set: the first word is dropped, so words 2 and 3 form the first couple, then words 4 and 5.
- R8: Samples are 16 bits wide. Bits beyond the 16th in one word clock half-period are ignored. In a short word the positions never received read as zero: the low positions for MSB-first words, the high positions for LSB-first words.
- R9: Each complete couple produces exactly one single-cycle `out_valid` pulse, with `out_left` and `out_right` holding the two samples.
- R10: `overflow` goes high in the cycle after an `out_valid` pulse during which `out_ready` was low. It then stays high until a reset or `sw_rst`.
- R11: A format write whose value differs from the stored one discards any partial word and pairing state. The next word clock change after a fresh reference starts a new first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset |
| sw_rst | input | 1 | Synchronous software reset pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 format, 1 source |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ser_bclk | input | 1 | Serial bit clock |
| ser_wclk | input | 1 | Serial word (left/right) clock |
| ser_data | input | 1 | Serial data |
| alt_valid | input | 1 | Alternate stream sample pair valid |
| alt_left | input | 16 | Alternate stream left sample |
| alt_right | input | 16 | Alternate stream right sample |
| out_ready | input | 1 | Consumer ready |
| out_valid | output | 1 | Output pair valid pulse |
| out_left | output | 16 | Output left sample |
| out_right | output | 16 | Output right sample |
| overflow | output | 1 | Sticky overflow flag |

## Verification
A wrong framing state shows up at the output within one word clock half-period. A lost or stale word boundary makes the next pair arrive with shifted bits, swapped channels, or a missing or extra `out_valid` pulse. Pairing-phase errors and a missed restart only appear one full couple later, so the tests send at least two couples after each configuration change. Register and overflow faults show up at `reg_rdata` and `overflow` one cycle after the access.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    typedef enum logic [1:0] {
        FR_SEEK,
        FR_HUNT,
        FR_WORD
    } fr_state_t;

    // Format register layout, bit 0 is the LSB
    typedef struct packed {
        logic pair_shift;   // bit 4
        logic lr_invert;    // bit 3
        logic fall_edge;    // bit 2
        logic msb_first;    // bit 1
        logic i2s_mode;     // bit 0
    } fmt_cfg_t;

    localparam int CFG_W = $bits(fmt_cfg_t);

endpackage

// File: rtl/sarx_edge.sv
module sarx_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic wclk_in,
    input  logic data_in,
    input  logic fall_edge,
    output logic bit_stb,
    output logic wclk_out,
    output logic data_out
);
    localparam int LANES = 3;

    logic [LANES-1:0] chain_q [STAGES];
    logic             bclk_d_q;
    logic             bclk_now;

    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= {bclk_in, wclk_in, data_in};
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign bclk_now = chain_q[STAGES-1][2];
    assign wclk_out = chain_q[STAGES-1][1];
    assign data_out = chain_q[STAGES-1][0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_d_q <= 1'b0;
        else        bclk_d_q <= bclk_now;
    end

    assign bit_stb = fall_edge ? (bclk_d_q & ~bclk_now) : (~bclk_d_q & bclk_now);

endmodule

// File: rtl/sarx_deser.sv
module sarx_deser
    import sarx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              bit_stb,
    input  logic              lr_in,
    input  logic              bit_in,
    input  logic              i2s_mode,
    input  logic              msb_first,
    output logic              word_stb,
    output logic [WORD_W-1:0] word_data,
    output logic              word_lr
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    fr_state_t         state_q, state_d;
    logic [WORD_W-1:0] acc_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              side_q;
    logic              lr_prev_q;
    logic              boundary;

    assign boundary = (lr_in != lr_prev_q);

    function automatic logic [WORD_W-1:0] place(
        input logic [WORD_W-1:0] a,
        input logic [CNT_W-1:0]  n,
        input logic              b,
        input logic              msb
    );
        logic [WORD_W-1:0] r;
        r = a;
        for (int i = 0; i < WORD_W; i++) begin
            if (n < CNT_W'(WORD_W) && int'(n) == (msb ? (WORD_W - 1 - i) : i))
                r[i] = b;
        end
        return r;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_SEEK;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = FR_SEEK;
        end else if (bit_stb) begin
            unique case (state_q)
                FR_SEEK: state_d = FR_HUNT;
                FR_HUNT: if (boundary) state_d = FR_WORD;
                FR_WORD: state_d = FR_WORD;
                default: state_d = FR_SEEK;
            endcase
        end
    end

    // word assembly and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            cnt_q     <= '0;
            side_q    <= 1'b0;
            lr_prev_q <= 1'b0;
            word_stb  <= 1'b0;
            word_data <= '0;
            word_lr   <= 1'b0;
        end else begin
            word_stb <= 1'b0;
            if (restart) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else if (bit_stb) begin
                lr_prev_q <= lr_in;
                unique case (state_q)
                    FR_SEEK: ;
                    FR_HUNT: begin
                        if (boundary) begin
                            side_q <= lr_in;
                            if (i2s_mode) begin
                                acc_q <= '0;
                                cnt_q <= '0;
                            end else begin
                                acc_q <= place('0, '0, bit_in, msb_first);
                                cnt_q <= CNT_W'(1);
                            end
                        end
                    end
                    FR_WORD: begin
                        if (boundary) begin
                            word_stb <= 1'b1;
                            word_lr  <= side_q;
                            side_q   <= lr_in;
                            if (i2s_mode) begin
                                word_data <= place(acc_q, cnt_q, bit_in, msb_first);
                                acc_q     <= '0;
                                cnt_q     <= '0;
                            end else begin
                                word_data <= acc_q;
                                acc_q     <= place('0, '0, bit_in, msb_first);
                                cnt_q     <= CNT_W'(1);
                            end
                        end else begin
                            acc_q <= place(acc_q, cnt_q, bit_in, msb_first);
                            if (cnt_q < CNT_W'(WORD_W)) cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sarx_pair.sv
module sarx_pair #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              word_stb,
    input  logic [WORD_W-1:0] word_data,
    input  logic              word_lr,
    input  logic              lr_invert,
    input  logic              pair_shift,
    output logic              pair_stb,
    output logic [WORD_W-1:0] pair_left,
    output logic [WORD_W-1:0] pair_right
);
    logic              phase_q;
    logic              skip_done_q;
    logic [WORD_W-1:0] hold_l_q, hold_r_q;
    logic              is_left;

    assign is_left = ((word_lr ^ lr_invert) == 1'b0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q     <= 1'b0;
            skip_done_q <= 1'b0;
            hold_l_q    <= '0;
            hold_r_q    <= '0;
            pair_stb    <= 1'b0;
            pair_left   <= '0;
            pair_right  <= '0;
        end else begin
            pair_stb <= 1'b0;
            if (restart) begin
                phase_q     <= 1'b0;
                skip_done_q <= 1'b0;
            end else if (word_stb) begin
                skip_done_q <= 1'b1;
                if (!(pair_shift && !skip_done_q)) begin
                    if (!phase_q) begin
                        if (is_left) hold_l_q <= word_data;
                        else         hold_r_q <= word_data;
                        phase_q <= 1'b1;
                    end else begin
                        pair_stb   <= 1'b1;
                        pair_left  <= is_left ? word_data : hold_l_q;
                        pair_right <= is_left ? hold_r_q  : word_data;
                        phase_q    <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int SAMPLE_W    = 16,
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_rst,
    input  logic                reg_wr,
    input  logic                reg_sel,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                ser_bclk,
    input  logic                ser_wclk,
    input  logic                ser_data,
    input  logic                alt_valid,
    input  logic [SAMPLE_W-1:0] alt_left,
    input  logic [SAMPLE_W-1:0] alt_right,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right,
    output logic                overflow
);
    fmt_cfg_t            cfg_q;
    logic                en_q;
    logic                restart;
    logic                wdata_unused;
    logic                bit_stb, wclk_s, data_s;
    logic                word_stb, word_lr;
    logic [SAMPLE_W-1:0] word_data;
    logic                pair_stb;
    logic [SAMPLE_W-1:0] pair_left, pair_right;

    assign wdata_unused = ^reg_wdata[REG_W-1:CFG_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            en_q  <= 1'b0;
        end else if (sw_rst) begin
            cfg_q <= '0;
            en_q  <= 1'b0;
        end else if (reg_wr) begin
            if (reg_sel) en_q  <= reg_wdata[0];
            else         cfg_q <= fmt_cfg_t'(reg_wdata[CFG_W-1:0]);
        end
    end

    assign restart   = sw_rst | (reg_wr & ~reg_sel & (reg_wdata[CFG_W-1:0] != cfg_q));
    assign reg_rdata = reg_sel ? REG_W'(en_q) : REG_W'(cfg_q);

    sarx_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .bclk_in(ser_bclk), .wclk_in(ser_wclk), .data_in(ser_data),
        .fall_edge(cfg_q.fall_edge),
        .bit_stb(bit_stb), .wclk_out(wclk_s), .data_out(data_s)
    );

    sarx_deser #(.WORD_W(SAMPLE_W)) u_deser (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .bit_stb(bit_stb), .lr_in(wclk_s), .bit_in(data_s),
        .i2s_mode(cfg_q.i2s_mode), .msb_first(cfg_q.msb_first),
        .word_stb(word_stb), .word_data(word_data), .word_lr(word_lr)
    );

    sarx_pair #(.WORD_W(SAMPLE_W)) u_pair (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .word_stb(word_stb), .word_data(word_data), .word_lr(word_lr),
        .lr_invert(cfg_q.lr_invert), .pair_shift(cfg_q.pair_shift),
        .pair_stb(pair_stb), .pair_left(pair_left), .pair_right(pair_right)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
            overflow  <= 1'b0;
        end else begin
            out_valid <= en_q ? pair_stb : alt_valid;
            if (en_q && pair_stb) begin
                out_left  <= pair_left;
                out_right <= pair_right;
            end else if (!en_q && alt_valid) begin
                out_left  <= alt_left;
                out_right <= alt_right;
            end
            if (sw_rst)                      overflow <= 1'b0;
            else if (out_valid && !out_ready) overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
    parameter int SAMPLE_W = 16,
    parameter int REG_W    = 8,
    parameter int CFG_W    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sw_rst,
    input logic                reg_wr,
    input logic                reg_sel,
    input logic [REG_W-1:0]    reg_rdata,
    input logic                alt_valid,
    input logic [SAMPLE_W-1:0] alt_left,
    input logic [SAMPLE_W-1:0] alt_right,
    input logic                out_ready,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_left,
    input logic [SAMPLE_W-1:0] out_right,
    input logic                overflow,
    input logic                src_en
);
    // R1
    fmt_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> reg_rdata[REG_W-1:CFG_W] == '0);

    // R1
    swrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (reg_rdata == '0 && !overflow));

    // R2
    alt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_en && alt_valid && !reg_wr) |=>
            (out_valid && out_left == $past(alt_left) && out_right == $past(alt_right)));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en && $past(src_en) && out_valid) |=> !out_valid);

    // R10
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !sw_rst) |=> overflow);

    // R10
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !sw_rst) |=> overflow);

endmodule

bind serial_audio_rx serial_audio_rx_chk #(
    .SAMPLE_W(SAMPLE_W), .REG_W(REG_W), .CFG_W(sarx_pkg::CFG_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_rdata(reg_rdata), .alt_valid(alt_valid), .alt_left(alt_left),
    .alt_right(alt_right), .out_ready(out_ready), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right), .overflow(overflow), .src_en(en_q)
);

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        ser_bclk = 1'b0, ser_wclk = 1'b0, ser_data = 1'b0;
    logic        alt_valid = 1'b0;
    logic [15:0] alt_left = '0, alt_right = '0;
    logic        out_ready = 1'b1;
    logic        out_valid;
    logic [15:0] out_left, out_right;
    logic        overflow;

    int n_chk = 0;
    int n_err = 0;
    int np = 0;
    logic [15:0] gl [8];
    logic [15:0] gr [8];
    logic [15:0] wq [8];
    logic [4:0]  cur_cfg = '0;
    logic        tx_i2s = 1'b0, tx_msb = 1'b0, tx_fall = 1'b0;

    always #10 clk = ~clk;

    serial_audio_rx uut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ser_bclk(ser_bclk), .ser_wclk(ser_wclk), .ser_data(ser_data),
        .alt_valid(alt_valid), .alt_left(alt_left), .alt_right(alt_right),
        .out_ready(out_ready), .out_valid(out_valid), .out_left(out_left),
        .out_right(out_right), .overflow(overflow)
    );

    always @(negedge clk) begin
        if (out_valid) begin
            if (np < 8) begin
                gl[np] = out_left;
                gr[np] = out_right;
            end
            np = np + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic reg_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic reg_read(input logic sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
        reg_sel = 1'b0;
    endtask

    task automatic set_cfg(input logic [4:0] v);
        reg_write(1'b0, {3'b000, v});
        cur_cfg = v;
        tx_i2s = v[0]; tx_msb = v[1]; tx_fall = v[2];
    endtask

    task automatic clear_mon();
        @(posedge clk);
        np = 0;
    endtask

    function automatic logic wbit(input logic [15:0] v, input int n);
        if (n >= 16) return 1'b1;
        return tx_msb ? v[15-n] : v[n];
    endfunction

    task automatic tx_bit(input logic lr, input logic d);
        @(negedge clk);
        ser_bclk = tx_fall; ser_wclk = lr; ser_data = d;
        repeat (4) @(negedge clk);
        ser_bclk = ~tx_fall;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_seq(input int n, input int nbits, input logic l0,
                            input logic resync, input logic close);
        logic lvl;
        logic b;
        if (resync) begin
            reg_write(1'b0, {3'b000, cur_cfg ^ 5'h10});
            reg_write(1'b0, {3'b000, cur_cfg});
            clear_mon();
        end
        tx_bit(~l0, 1'b0);
        tx_bit(~l0, 1'b0);
        for (int k = 0; k < n; k++) begin
            lvl = l0 ^ k[0];
            for (int j = 0; j < nbits; j++) begin
                if (tx_i2s)
                    b = (j == 0) ? ((k == 0) ? 1'b0 : wbit(wq[k-1], nbits - 1))
                                 : wbit(wq[k], j - 1);
                else
                    b = wbit(wq[k], j);
                tx_bit(lvl, b);
            end
        end
        if (close) begin
            lvl = l0 ^ n[0];
            tx_bit(lvl, tx_i2s ? wbit(wq[n-1], nbits - 1) : 1'b0);
            tx_bit(lvl, 1'b0);
        end
        repeat (20) @(posedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        reg_read(1'b0, d); check("R1 format reg after reset", d, 8'h00);
        reg_read(1'b1, d); check("R1 source reg after reset", d, 8'h00);
        check("R1 overflow after reset", overflow, 1'b0);
        check("R9 out_valid idle after reset", out_valid, 1'b0);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        reg_write(1'b0, 8'hFF); reg_read(1'b0, d); check("R1 format reg upper bits", d, 8'h1F);
        reg_write(1'b1, 8'hFF); reg_read(1'b1, d); check("R1 source reg upper bits", d, 8'h01);
    endtask

    task automatic t_aligned_msb();
        set_cfg(5'h02);
        wq[0] = 16'h1234; wq[1] = 16'hABCD; wq[2] = 16'h8001; wq[3] = 16'h7FFE;
        send_seq(4, 16, 1'b0, 1'b1, 1'b1);
        check("R9 R3 aligned pair count", np, 2);
        check("R3 R4 R5 aligned left0", gl[0], 16'h1234);
        check("R3 R4 R5 aligned right0", gr[0], 16'hABCD);
        check("R3 R4 aligned left1", gl[1], 16'h8001);
        check("R3 R4 aligned right1", gr[1], 16'h7FFE);
    endtask

    task automatic t_i2s_lsb_fall();
        set_cfg(5'h05);
        wq[0] = 16'hC3A5; wq[1] = 16'h0F0F; wq[2] = 16'h8000; wq[3] = 16'h0001;
        send_seq(4, 16, 1'b0, 1'b1, 1'b1);
        check("R3 R5 i2s pair count", np, 2);
        check("R3 R4 R5 i2s left0", gl[0], 16'hC3A5);
        check("R3 R4 R5 i2s right0", gr[0], 16'h0F0F);
        check("R3 R4 R5 i2s left1", gl[1], 16'h8000);
        check("R3 R4 R5 i2s right1", gr[1], 16'h0001);
    endtask

    task automatic t_polarity();
        set_cfg(5'h0A);
        wq[0] = 16'h1111; wq[1] = 16'h2222;
        send_seq(2, 16, 1'b0, 1'b1, 1'b1);
        check("R6 invert pair count", np, 1);
        check("R6 low level is right when inverted", gr[0], 16'h1111);
        check("R6 high level is left when inverted", gl[0], 16'h2222);
    endtask

    task automatic t_shift();
        set_cfg(5'h12);
        wq[0] = 16'hDEAD; wq[1] = 16'h0B0B; wq[2] = 16'h0C0C; wq[3] = 16'h0D0D; wq[4] = 16'h0E0E;
        send_seq(5, 16, 1'b0, 1'b1, 1'b1);
        check("R7 shifted pair count", np, 2);
        check("R7 first couple right (word 2)", gr[0], 16'h0B0B);
        check("R7 first couple left (word 3)", gl[0], 16'h0C0C);
        check("R7 second couple right (word 4)", gr[1], 16'h0D0D);
        check("R7 second couple left (word 5)", gl[1], 16'h0E0E);
    endtask

    task automatic t_length();
        set_cfg(5'h02);
        wq[0] = 16'hABCD; wq[1] = 16'h1357;
        send_seq(2, 12, 1'b0, 1'b1, 1'b1);
        check("R8 short msb count", np, 1);
        check("R8 short msb left zero-padded", gl[0], 16'hABC0);
        check("R8 short msb right zero-padded", gr[0], 16'h1350);
        set_cfg(5'h00);
        wq[0] = 16'h5A3C; wq[1] = 16'hF00D;
        send_seq(2, 20, 1'b0, 1'b1, 1'b1);
        check("R8 long lsb count", np, 1);
        check("R8 long lsb left extra ignored", gl[0], 16'h5A3C);
        check("R8 long lsb right extra ignored", gr[0], 16'hF00D);
    endtask

    task automatic t_source();
        set_cfg(5'h02);
        reg_write(1'b1, 8'h00);
        wq[0] = 16'h4444; wq[1] = 16'h5555;
        send_seq(2, 16, 1'b0, 1'b1, 1'b1);
        check("R2 serial pair blocked when source clear", np, 0);
        clear_mon();
        @(negedge clk);
        alt_valid = 1'b1; alt_left = 16'hA1A1; alt_right = 16'hB2B2;
        @(negedge clk);
        alt_valid = 1'b0;
        repeat (4) @(posedge clk);
        check("R2 alternate pulse count", np, 1);
        check("R2 alternate left", gl[0], 16'hA1A1);
        check("R2 alternate right", gr[0], 16'hB2B2);
        reg_write(1'b1, 8'h01);
        clear_mon();
        @(negedge clk);
        alt_valid = 1'b1;
        @(negedge clk);
        alt_valid = 1'b0;
        repeat (4) @(posedge clk);
        check("R2 alternate ignored when source set", np, 0);
    endtask

    task automatic t_overflow();
        logic [7:0] d;
        set_cfg(5'h02);
        out_ready = 1'b0;
        wq[0] = 16'h0101; wq[1] = 16'h0202;
        send_seq(2, 16, 1'b0, 1'b1, 1'b1);
        check("R10 overflow set when not ready", overflow, 1'b1);
        out_ready = 1'b1;
        send_seq(2, 16, 1'b0, 1'b1, 1'b1);
        check("R10 overflow sticky", overflow, 1'b1);
        check("R10 pair still delivered", np, 1);
        @(negedge clk); sw_rst = 1'b1;
        @(negedge clk); sw_rst = 1'b0;
        check("R1 overflow cleared by sw_rst", overflow, 1'b0);
        reg_read(1'b0, d); check("R1 format reg cleared by sw_rst", d, 8'h00);
        reg_read(1'b1, d); check("R1 source reg cleared by sw_rst", d, 8'h00);
        reg_write(1'b1, 8'h01);
        cur_cfg = '0; tx_i2s = 1'b0; tx_msb = 1'b0; tx_fall = 1'b0;
    endtask

    task automatic t_restart();
        set_cfg(5'h02);
        wq[0] = 16'h1A1A; wq[1] = 16'h2B2B; wq[2] = 16'h3C3C;
        send_seq(3, 16, 1'b0, 1'b1, 1'b0);
        check("R11 pair before change", np, 1);
        set_cfg(5'h00);
        clear_mon();
        wq[0] = 16'h6D6D; wq[1] = 16'h7E7E;
        send_seq(2, 16, 1'b0, 1'b0, 1'b1);
        check("R11 pairs after change", np, 1);
        check("R11 fresh left", gl[0], 16'h6D6D);
        check("R11 fresh right", gr[0], 16'h7E7E);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(posedge clk);
        t_reset();
        t_regs();
        reg_write(1'b1, 8'h01);
        t_aligned_msb();
        t_i2s_lsb_fall();
        t_polarity();
        t_shift();
        t_length();
        t_source();
        t_overflow();
        t_restart();
        report();
    end

endmodule